// File: doc/BRIEF.md
# Bridge Master Abort Responder

This block sits beside the bus engines of a PCI-to-PCI bridge and decides what happens when a forwarded cycle finds no target on the far side. A single mode bit selects between two behaviours. In one, the abort is hidden: the cycle completes normally, with filler data or quietly dropped writes. In the other, the abort is reported: a target abort is signalled.

The block handles the two directions separately. For a cycle that a PCI initiator started and that went unclaimed upstream, the block chooses between a normal data-phase completion on PCI, with all-ones read data or a discarded write, and a target abort. For a cycle that the host side started and that went unclaimed on PCI, the block chooses the status code of the completion sent back upstream. A locked read always gets the completer-abort status, whatever the mode.

The bus engines present the facts of the failed cycle together with a one-cycle abort event. The decided response appears on the registered outputs one clock later, for exactly one cycle.

Top module: `bridge_mabort_resp`

## Requirements
- R1: While `rst` is high at a clock edge, every output is cleared to zero after that edge, even if an abort event is presented.
- R2: The response to an abort event appears on the outputs in the cycle after the event and lasts one cycle. After any cycle without `abort_evt_i`, all flag outputs, `pci_rdata_o` and `cpl_vld_o` are zero.
- R3: `abort_orig_i` = 0 marks a PCI-originated cycle and 1 marks a host-originated cycle. For a PCI-originated abort with `abort_mode_i` = 0, `pci_trdy_o` is 1, `pci_tabort_o` is 0 and `cpl_vld_o` is 0.
- R4: In the case of R3, a read (`abort_write_i` = 0) sets `pci_rd_ones_o` and drives `pci_rdata_o` to all ones with `pci_wr_discard_o` = 0. A write sets `pci_wr_discard_o` with `pci_rd_ones_o` = 0 and `pci_rdata_o` = 0.
- R5: For a PCI-originated abort with `abort_mode_i` = 1, `pci_tabort_o` is 1 and `pci_trdy_o`, `pci_rd_ones_o`, `pci_wr_discard_o` and `cpl_vld_o` are 0, for reads and writes alike.
- R6: `abort_locked_i` has no effect on the response to a PCI-originated abort.
- R7: For a host-originated non-locked read abort, `cpl_vld_o` is 1 and `cpl_status_o` is 2'b00 (normal) in mode 0 and 2'b01 (target abort) in mode 1. No PCI-side output is set.
- R8: For a host-originated locked read abort, `cpl_vld_o` is 1 and `cpl_status_o` is 2'b10 (completer abort) in both modes.
- R9: A host-originated write abort, locked or not, produces no completion (`cpl_vld_o` = 0) and sets no PCI-side output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| abort_mode_i | input | 1 | 0 = complete silently, 1 = signal abort |
| abort_evt_i | input | 1 | One-cycle pulse: the described cycle master-aborted |
| abort_orig_i | input | 1 | 0 = started on PCI, 1 = started on the host side |
| abort_write_i | input | 1 | 1 = write, 0 = read |
| abort_locked_i | input | 1 | Cycle is part of a locked sequence |
| pci_trdy_o | output | 1 | Complete the PCI data phase normally |
| pci_tabort_o | output | 1 | Terminate the PCI cycle with target abort |
| pci_rd_ones_o | output | 1 | Read data is being overridden with all ones |
| pci_rdata_o | output | DATA_W | Override read data (all ones when used, else zero) |
| pci_wr_discard_o | output | 1 | Drop the write data |
| cpl_vld_o | output | 1 | Send a completion upstream |
| cpl_status_o | output | 2 | Completion status: 00 normal, 01 target abort, 10 completer abort |

## Verification
The bench walks all sixteen combinations of mode, origin, direction and lock flag, first with idle cycles between events and then back to back. The spaced run shows that each response lasts only one cycle. The back-to-back run shows that each response follows its own event and not a neighbour's. Comparing matching pairs that differ only in the lock flag separates the locked-read override from the mode-driven status, and shows that the flag is ignored on PCI-originated cycles. Presenting an event during reset shows that reset takes precedence.

// File: rtl/bma_pkg.sv
package bma_pkg;

    typedef enum logic {
        ORIG_PCI  = 1'b0,
        ORIG_HOST = 1'b1
    } orig_e;

    typedef enum logic [1:0] {
        CPL_NORMAL          = 2'b00,
        CPL_TGT_ABORT       = 2'b01,
        CPL_COMPLETER_ABORT = 2'b10
    } cpl_e;

    typedef struct packed {
        orig_e orig;
        logic  write;
        logic  locked;
        logic  mode;
    } abort_req_t;

    typedef struct packed {
        logic trdy;
        logic tabort;
        logic rd_ones;
        logic wr_discard;
    } pci_resp_t;

    typedef struct packed {
        logic vld;
        cpl_e status;
    } host_cpl_t;

    function automatic pci_resp_t pci_resp_idle();
        pci_resp_t r;
        r = '{trdy: 1'b0, tabort: 1'b0, rd_ones: 1'b0, wr_discard: 1'b0};
        return r;
    endfunction

    function automatic host_cpl_t host_cpl_idle();
        host_cpl_t c;
        c = '{vld: 1'b0, status: CPL_NORMAL};
        return c;
    endfunction

    function automatic cpl_e status_for(input logic locked, input logic mode);
        if (locked)
            return CPL_COMPLETER_ABORT;
        else if (mode)
            return CPL_TGT_ABORT;
        else
            return CPL_NORMAL;
    endfunction

endpackage

// File: rtl/bma_pci_decide.sv
module bma_pci_decide
    import bma_pkg::*;
(
    input  logic       fire_i,
    input  abort_req_t req_i,
    output pci_resp_t  resp_o
);

    always_comb begin
        resp_o = pci_resp_idle();
        if (fire_i && req_i.orig == ORIG_PCI) begin
            if (req_i.mode) begin
                resp_o.tabort = 1'b1;
            end else begin
                resp_o.trdy       = 1'b1;
                resp_o.rd_ones    = !req_i.write;
                resp_o.wr_discard = req_i.write;
            end
        end
    end

endmodule

// File: rtl/bma_host_decide.sv
module bma_host_decide
    import bma_pkg::*;
(
    input  logic       fire_i,
    input  abort_req_t req_i,
    output host_cpl_t  cpl_o
);

    always_comb begin
        cpl_o = host_cpl_idle();
        if (fire_i && req_i.orig == ORIG_HOST && !req_i.write) begin
            cpl_o.vld    = 1'b1;
            cpl_o.status = status_for(req_i.locked, req_i.mode);
        end
    end

endmodule

// File: rtl/bma_resp_reg.sv
module bma_resp_reg
    import bma_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  pci_resp_t         pci_d,
    input  host_cpl_t         cpl_d,
    output pci_resp_t         pci_q,
    output host_cpl_t         cpl_q,
    output logic [DATA_W-1:0] rdata_q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            pci_q   <= pci_resp_idle();
            cpl_q   <= host_cpl_idle();
            rdata_q <= '0;
        end else begin
            pci_q   <= pci_d;
            cpl_q   <= cpl_d;
            rdata_q <= {DATA_W{pci_d.rd_ones}};
        end
    end

endmodule

// File: rtl/bridge_mabort_resp.sv
module bridge_mabort_resp
    import bma_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              abort_mode_i,
    input  logic              abort_evt_i,
    input  logic              abort_orig_i,
    input  logic              abort_write_i,
    input  logic              abort_locked_i,
    output logic              pci_trdy_o,
    output logic              pci_tabort_o,
    output logic              pci_rd_ones_o,
    output logic [DATA_W-1:0] pci_rdata_o,
    output logic              pci_wr_discard_o,
    output logic              cpl_vld_o,
    output logic [1:0]        cpl_status_o
);

    abort_req_t req;
    pci_resp_t  pci_d, pci_q;
    host_cpl_t  cpl_d, cpl_q;

    always_comb begin
        req.orig   = orig_e'(abort_orig_i);
        req.write  = abort_write_i;
        req.locked = abort_locked_i;
        req.mode   = abort_mode_i;
    end

    bma_pci_decide u_pci (
        .fire_i (abort_evt_i),
        .req_i  (req),
        .resp_o (pci_d)
    );

    bma_host_decide u_host (
        .fire_i (abort_evt_i),
        .req_i  (req),
        .cpl_o  (cpl_d)
    );

    bma_resp_reg #(.DATA_W(DATA_W)) u_reg (
        .clk     (clk),
        .rst     (rst),
        .pci_d   (pci_d),
        .cpl_d   (cpl_d),
        .pci_q   (pci_q),
        .cpl_q   (cpl_q),
        .rdata_q (pci_rdata_o)
    );

    assign pci_trdy_o       = pci_q.trdy;
    assign pci_tabort_o     = pci_q.tabort;
    assign pci_rd_ones_o    = pci_q.rd_ones;
    assign pci_wr_discard_o = pci_q.wr_discard;
    assign cpl_vld_o        = cpl_q.vld;
    assign cpl_status_o     = cpl_q.status;

    AST_IDLE_WITHOUT_EVT: assert property (@(posedge clk) disable iff (rst)
        !abort_evt_i |=> !(pci_trdy_o || pci_tabort_o || pci_rd_ones_o
                           || pci_wr_discard_o || cpl_vld_o) && pci_rdata_o == '0); // R2

    AST_PCI_SILENT: assert property (@(posedge clk) disable iff (rst)
        abort_evt_i && !abort_orig_i && !abort_mode_i
        |=> pci_trdy_o && !pci_tabort_o && !cpl_vld_o); // R3

    AST_RD_ALL_ONES: assert property (@(posedge clk) disable iff (rst)
        abort_evt_i && !abort_orig_i && !abort_mode_i && !abort_write_i
        |=> pci_rdata_o == {DATA_W{1'b1}} && !pci_wr_discard_o); // R4

    AST_WR_DISCARD: assert property (@(posedge clk) disable iff (rst)
        abort_evt_i && !abort_orig_i && !abort_mode_i && abort_write_i
        |=> pci_wr_discard_o && !pci_rd_ones_o); // R4

    AST_PCI_TABORT: assert property (@(posedge clk) disable iff (rst)
        abort_evt_i && !abort_orig_i && abort_mode_i
        |=> pci_tabort_o && !pci_trdy_o && !pci_rd_ones_o
            && !pci_wr_discard_o && !cpl_vld_o); // R5

    AST_UNLOCKED_STATUS: assert property (@(posedge clk) disable iff (rst)
        abort_evt_i && abort_orig_i && !abort_write_i && !abort_locked_i
        |=> cpl_vld_o && cpl_status_o == {1'b0, $past(abort_mode_i)}
            && !pci_trdy_o && !pci_tabort_o); // R7

    AST_LOCKED_RD_CA: assert property (@(posedge clk) disable iff (rst)
        abort_evt_i && abort_orig_i && !abort_write_i && abort_locked_i
        |=> cpl_vld_o && cpl_status_o == 2'b10); // R8

    AST_HOST_WR_NO_CPL: assert property (@(posedge clk) disable iff (rst)
        abort_evt_i && abort_orig_i && abort_write_i
        |=> !cpl_vld_o && !pci_trdy_o && !pci_tabort_o && !pci_wr_discard_o); // R9

    AST_TRDY_TABORT_EXCL: assert property (@(posedge clk) disable iff (rst)
        !(pci_trdy_o && pci_tabort_o)); // R5

endmodule

// File: tb/bridge_mabort_resp_tb_top.sv
module bridge_mabort_resp_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int DW         = 32;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic mode = 1'b0, evt = 1'b0, orig = 1'b0, wr = 1'b0, lk = 1'b0;
    logic trdy, tabort, rd_ones, wr_disc, cvld;
    logic [DW-1:0] rdata;
    logic [1:0] cst;

    always #(CLK_PERIOD/2) clk = ~clk;

    bridge_mabort_resp #(.DATA_W(DW)) dut_i (
        .clk              (clk),
        .rst              (rst),
        .abort_mode_i     (mode),
        .abort_evt_i      (evt),
        .abort_orig_i     (orig),
        .abort_write_i    (wr),
        .abort_locked_i   (lk),
        .pci_trdy_o       (trdy),
        .pci_tabort_o     (tabort),
        .pci_rd_ones_o    (rd_ones),
        .pci_rdata_o      (rdata),
        .pci_wr_discard_o (wr_disc),
        .cpl_vld_o        (cvld),
        .cpl_status_o     (cst)
    );

    // expected vector: {trdy, tabort, rd_ones, wr_discard, cpl_vld, status[1:0]}
    logic [6:0] exp_q[$];
    string      tag_q[$];
    int n_chk = 0;
    int n_err = 0;
    bit done  = 1'b0;

    function automatic logic [6:0] model(input logic e, input logic m, input logic o,
                                         input logic w, input logic l);
        logic [6:0] x;
        x = '0;
        if (e) begin
            if (!o) begin
                if (m) x[5] = 1'b1;
                else begin
                    x[6] = 1'b1;
                    if (w) x[3] = 1'b1; else x[4] = 1'b1;
                end
            end else if (!w) begin
                x[2]   = 1'b1;
                x[1:0] = l ? 2'b10 : (m ? 2'b01 : 2'b00);
            end
        end
        return x;
    endfunction

    function automatic string tag_of(input logic e, input logic m, input logic o,
                                     input logic w, input logic l);
        if (!e) return "R2";
        if (!o) return m ? "R5" : (l ? "R6" : (w ? "R4" : "R3"));
        if (w) return "R9";
        return l ? "R8" : "R7";
    endfunction

    function automatic logic [6:0] observed();
        return {trdy, tabort, rd_ones, wr_disc, cvld, cst};
    endfunction

    task automatic check(input string tag, input logic [6:0] exp_v);
        logic [DW-1:0] exp_d;
        exp_d = {DW{exp_v[4]}};
        n_chk++;
        if (observed() !== exp_v || rdata !== exp_d) begin
            n_err++;
            $display("FAIL %s: outputs=%b rdata=%h expected=%b rdata=%h",
                     tag, observed(), rdata, exp_v, exp_d);
        end
    endtask

    task automatic drive(input logic e, input logic m, input logic o,
                         input logic w, input logic l);
        @(negedge clk);
        evt = e; mode = m; orig = o; wr = w; lk = l;
        exp_q.push_back(model(e, m, o, w, l));
        tag_q.push_back(tag_of(e, m, o, w, l));
    endtask

    // monitor: one expected item per cycle, sampled after the edge
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (exp_q.size() > 0) check(tag_q.pop_front(), exp_q.pop_front());
        end
    end

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            n_chk++;
            n_err++;
            $display("FAIL watchdog: run did not finish, actual=hung expected=done");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

    initial begin
        // R1: event presented during reset must not reach the outputs
        evt = 1'b1; orig = 1'b0; mode = 1'b0; wr = 1'b0;
        repeat (3) @(posedge clk);
        #1;
        check("R1", 7'b0);
        @(negedge clk);
        rst = 1'b0; evt = 1'b0;
        drive(0, 0, 0, 0, 0);

        // spaced events: each response one cycle, idle after
        for (int i = 0; i < 16; i++) begin
            drive(1, i[3], i[2], i[1], i[0]);
            drive(0, i[3], i[2], i[1], i[0]);
        end
        // back to back, reverse order
        for (int i = 15; i >= 0; i--) drive(1, i[3], i[2], i[1], i[0]);
        // R6: lock flag toggled on PCI-originated cycles
        drive(1, 0, 0, 0, 1);
        drive(1, 0, 0, 0, 0);
        drive(1, 1, 0, 1, 1);
        drive(1, 0, 0, 1, 1);
        // R8 in both modes back to back, then R7 neighbours
        drive(1, 0, 1, 0, 1);
        drive(1, 1, 1, 0, 1);
        drive(1, 1, 1, 0, 0);
        drive(1, 0, 1, 0, 0);
        // R2: stimulus fields change but no event
        drive(0, 1, 1, 0, 1);
        drive(0, 0, 0, 0, 0);
        drive(0, 0, 0, 0, 0);

        while (exp_q.size() > 0) @(posedge clk);
        @(posedge clk);
        #2;
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

endmodule